// File: doc/BRIEF.md
# Boot Region Write Protection Controller

This block guards the boot region of a 512K x 8 flash command engine. It keeps two independent protection settings, one for the low end and one for the high end of the 19-bit address space. Each setting is either open or locked over a 16 KB or 64 KB window. The command decoder sends it a lock request once it has recognised a full lock sequence. It also sends every program or erase request that it is about to start, and the block returns a single-cycle verdict that either lets the operation go ahead or refuses it.

The lock request carries the final command byte and the final address of the sequence. The byte picks the window size and the address picks the end of the space. A locked end stays locked until the dedicated factory-clear input is raised, which stands in for non-volatile storage. In identification mode the engine reads the protection status from two fixed addresses. The block answers with a byte whose two low bits give the lock size of that end.

Top module: `bootlock_ctrl`

## Requirements
- R1: While `factory_rst` is high, both settings are cleared on the clock edge. Afterwards both status reads return 00h and every operation is allowed.
- R2: A lock request with `lock_code` 40h selects the 16 KB size and 70h selects the 64 KB size. `lock_addr` 7FFFFh applies it to the high end and 00000h applies it to the low end.
- R3: A lock request with any other code byte, or with any other address, changes neither setting.
- R4: Once an end is locked, later lock requests for that end are ignored until `factory_rst`.
- R5: `rst` clears `op_done`, `op_allow` and `op_reject` but leaves both lock settings unchanged.
- R6: The high-end window covers 7C000h–7FFFFh (16 KB) or 70000h–7FFFFh (64 KB). The low-end window covers 00000h–03FFFh (16 KB) or 00000h–0FFFFh (64 KB).
- R7: A byte program (`op_kind` 00) is refused exactly when its address falls inside a locked window.
- R8: A page erase (`op_kind` 01, the 4 KB page holding `op_addr`) or a sector erase (`op_kind` 10, the 64 KB sector holding `op_addr`) is refused as a whole exactly when that range overlaps a locked window.
- R9: A chip erase (`op_kind` 11) is refused whenever either end is locked.
- R10: One clock after `op_valid`, `op_done` pulses for one cycle together with exactly one of `op_allow` or `op_reject`. With no request, `op_done` stays low.
- R11: `id_addr` 00002h returns the low-end status and 7FFF2h the high-end status on `id_status`, with `id_hit` high. Bits [1:0] are 10b for 16 KB, 11b for 64 KB and 00b for open, and bits [7:2] are zero. Every other address gives 00h with `id_hit` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the verdict outputs |
| factory_rst | input | 1 | Synchronous clear of both lock settings |
| lock_req | input | 1 | A lock sequence has completed |
| lock_code | input | 8 | Final command byte of the lock sequence |
| lock_addr | input | 19 | Final address of the lock sequence |
| op_valid | input | 1 | Program or erase request |
| op_kind | input | 2 | 00 program, 01 page erase, 10 sector erase, 11 chip erase |
| op_addr | input | 19 | Target address of the request |
| op_done | output | 1 | Verdict valid pulse |
| op_allow | output | 1 | Request may proceed |
| op_reject | output | 1 | Request refused |
| id_addr | input | 19 | Identification-mode read address |
| id_hit | output | 1 | `id_addr` is one of the two status addresses |
| id_status | output | 8 | Status byte for `id_addr` |

## Verification
A wrong stored setting appears at once on the combinational status byte. It also appears in the first verdict after it, either as a wrong reject at a window edge or as a missing one. A wrong bound or a wrong operation range appears only for requests near a window edge. For that reason the sweep drives every operation kind at the addresses just inside and just outside each possible window edge, under all nine lock combinations. A wrong verdict is visible one clock after the request.

// File: rtl/bootlock_pkg.sv
package bootlock_pkg;

    localparam int ADDR_W = 19;

    localparam logic [7:0] CODE_SMALL = 8'h40;
    localparam logic [7:0] CODE_LARGE = 8'h70;

    // Encoding equals the status bits [1:0] returned on readback
    typedef enum logic [1:0] {
        LK_NONE  = 2'b00,
        LK_SMALL = 2'b10,
        LK_LARGE = 2'b11
    } lock_e;

    typedef enum logic [1:0] {
        OP_PROG  = 2'b00,
        OP_PAGE  = 2'b01,
        OP_SECT  = 2'b10,
        OP_CHIP  = 2'b11
    } op_kind_e;

    function automatic lock_e size_from_code(input logic [7:0] code);
        if (code == CODE_SMALL)      return LK_SMALL;
        else if (code == CODE_LARGE) return LK_LARGE;
        else                         return LK_NONE;
    endfunction

endpackage

// File: rtl/bootlock_store.sv
module bootlock_store
    import bootlock_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          factory_rst,
    input  logic          lock_req,
    input  logic [7:0]    lock_code,
    input  logic [AW-1:0] lock_addr,
    output lock_e         bot_code,
    output lock_e         top_code
);

    lock_e req_size;
    logic  anchor_top;
    logic  anchor_bot;

    always_comb begin
        req_size   = size_from_code(lock_code);
        anchor_top = (lock_addr == {AW{1'b1}});
        anchor_bot = (lock_addr == {AW{1'b0}});
    end

    // Settings survive the ordinary reset; only the factory clear opens them
    always_ff @(posedge clk) begin
        if (factory_rst) begin
            bot_code <= LK_NONE;
            top_code <= LK_NONE;
        end else if (lock_req && req_size != LK_NONE) begin
            if (anchor_top && top_code == LK_NONE) top_code <= req_size;
            if (anchor_bot && bot_code == LK_NONE) bot_code <= req_size;
        end
    end

endmodule

// File: rtl/bootlock_window.sv
module bootlock_window
    import bootlock_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int SMALL_W = 14,
    parameter int LARGE_W = 16,
    parameter bit AT_TOP  = 1'b0
) (
    input  lock_e         code,
    output logic          active,
    output logic [AW-1:0] lo,
    output logic [AW-1:0] hi
);

    localparam logic [AW-1:0] SMALL_SPAN = {{(AW-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};
    localparam logic [AW-1:0] LARGE_SPAN = {{(AW-LARGE_W){1'b0}}, {LARGE_W{1'b1}}};

    logic [AW-1:0] span;

    always_comb begin
        active = (code != LK_NONE);
        span   = (code == LK_LARGE) ? LARGE_SPAN : SMALL_SPAN;
    end

    generate
        if (AT_TOP) begin : g_top
            assign lo = ~span;
            assign hi = {AW{1'b1}};
        end else begin : g_bot
            assign lo = {AW{1'b0}};
            assign hi = span;
        end
    endgenerate

endmodule

// File: rtl/bootlock_gate.sv
module bootlock_gate
    import bootlock_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int PAGE_W = 12,
    parameter int SECT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  op_kind_e            op_kind,
    input  logic [AW-1:0]       op_addr,
    input  logic [1:0]          win_act,
    input  logic [1:0][AW-1:0]  win_lo,
    input  logic [1:0][AW-1:0]  win_hi,
    output logic                op_done,
    output logic                op_allow,
    output logic                op_reject
);

    localparam logic [AW-1:0] PAGE_MASK = {{(AW-PAGE_W){1'b0}}, {PAGE_W{1'b1}}};
    localparam logic [AW-1:0] SECT_MASK = {{(AW-SECT_W){1'b0}}, {SECT_W{1'b1}}};

    logic [AW-1:0] rng_lo;
    logic [AW-1:0] rng_hi;
    logic [1:0]    overlap;
    logic          hit;

    always_comb begin
        unique case (op_kind)
            OP_PROG: begin rng_lo = op_addr;              rng_hi = op_addr;             end
            OP_PAGE: begin rng_lo = op_addr & ~PAGE_MASK; rng_hi = op_addr | PAGE_MASK; end
            OP_SECT: begin rng_lo = op_addr & ~SECT_MASK; rng_hi = op_addr | SECT_MASK; end
            default: begin rng_lo = {AW{1'b0}};           rng_hi = {AW{1'b1}};          end
        endcase
    end

    for (genvar w = 0; w < 2; w++) begin : g_ovl
        assign overlap[w] = win_act[w] && (rng_lo <= win_hi[w]) && (rng_hi >= win_lo[w]);
    end

    assign hit = |overlap;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_done   <= 1'b0;
            op_allow  <= 1'b0;
            op_reject <= 1'b0;
        end else begin
            op_done   <= op_valid;
            op_allow  <= op_valid && !hit;
            op_reject <= op_valid && hit;
        end
    end

endmodule

// File: rtl/bootlock_ctrl.sv
module bootlock_ctrl
    import bootlock_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int SMALL_W = 14,
    parameter int LARGE_W = 16,
    parameter int PAGE_W  = 12,
    parameter int SECT_W  = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          factory_rst,
    input  logic          lock_req,
    input  logic [7:0]    lock_code,
    input  logic [AW-1:0] lock_addr,
    input  logic          op_valid,
    input  logic [1:0]    op_kind,
    input  logic [AW-1:0] op_addr,
    output logic          op_done,
    output logic          op_allow,
    output logic          op_reject,
    input  logic [AW-1:0] id_addr,
    output logic          id_hit,
    output logic [7:0]    id_status
);

    localparam logic [AW-1:0] ID_BOT_ADDR = AW'(2);
    localparam logic [AW-1:0] ID_TOP_ADDR = ~AW'(13);

    lock_e              bot_code;
    lock_e              top_code;
    lock_e              loc_code [2];
    logic [1:0]         win_act;
    logic [1:0][AW-1:0] win_lo;
    logic [1:0][AW-1:0] win_hi;

    bootlock_store #(.AW(AW)) i_store (
        .clk         (clk),
        .factory_rst (factory_rst),
        .lock_req    (lock_req),
        .lock_code   (lock_code),
        .lock_addr   (lock_addr),
        .bot_code    (bot_code),
        .top_code    (top_code)
    );

    assign loc_code[0] = bot_code;
    assign loc_code[1] = top_code;

    // Index 0 guards the low end, index 1 the high end
    for (genvar g = 0; g < 2; g++) begin : g_win
        bootlock_window #(
            .AW      (AW),
            .SMALL_W (SMALL_W),
            .LARGE_W (LARGE_W),
            .AT_TOP  (1'(g == 1))
        ) i_win (
            .code   (loc_code[g]),
            .active (win_act[g]),
            .lo     (win_lo[g]),
            .hi     (win_hi[g])
        );
    end

    bootlock_gate #(.AW(AW), .PAGE_W(PAGE_W), .SECT_W(SECT_W)) i_gate (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_kind   (op_kind_e'(op_kind)),
        .op_addr   (op_addr),
        .win_act   (win_act),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .op_done   (op_done),
        .op_allow  (op_allow),
        .op_reject (op_reject)
    );

    always_comb begin
        id_hit    = 1'b0;
        id_status = 8'h00;
        if (id_addr == ID_BOT_ADDR) begin
            id_hit    = 1'b1;
            id_status = {6'b0, bot_code};
        end else if (id_addr == ID_TOP_ADDR) begin
            id_hit    = 1'b1;
            id_status = {6'b0, top_code};
        end
    end

endmodule

// File: rtl/bootlock_chk.sv
module bootlock_chk (
    input logic       clk,
    input logic       rst,
    input logic       factory_rst,
    input logic       op_valid,
    input logic [1:0] op_kind,
    input logic       op_done,
    input logic       op_allow,
    input logic       op_reject,
    input logic [1:0] bot_code,
    input logic [1:0] top_code
);

    // R10
    one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        op_done |-> ($countones({op_allow, op_reject}) == 1));

    // R10
    done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> op_done);

    // R10
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !op_done);

    // R4
    top_hold_chk: assert property (@(posedge clk) disable iff (factory_rst)
        (top_code != 2'b00) |=> $stable(top_code));

    // R4
    bot_hold_chk: assert property (@(posedge clk) disable iff (factory_rst)
        (bot_code != 2'b00) |=> $stable(bot_code));

    // R1
    factory_clear_chk: assert property (@(posedge clk) disable iff (rst)
        factory_rst |=> (top_code == 2'b00 && bot_code == 2'b00));

    // R9
    chip_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'b11 && (top_code != 2'b00 || bot_code != 2'b00)) |=> op_reject);

endmodule

bind bootlock_ctrl bootlock_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .factory_rst (factory_rst),
    .op_valid    (op_valid),
    .op_kind     (op_kind),
    .op_done     (op_done),
    .op_allow    (op_allow),
    .op_reject   (op_reject),
    .bot_code    (bot_code),
    .top_code    (top_code)
);

// File: tb/test_bootlock_ctrl.sv
module test_bootlock_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        factory_rst = 1'b1;
    logic        lock_req = 1'b0;
    logic [7:0]  lock_code = 8'h00;
    logic [18:0] lock_addr = '0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [18:0] op_addr = '0;
    logic        op_done, op_allow, op_reject;
    logic [18:0] id_addr = '0;
    logic        id_hit;
    logic [7:0]  id_status;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bootlock_ctrl i_bootlock_ctrl (
        .clk(clk), .rst(rst), .factory_rst(factory_rst),
        .lock_req(lock_req), .lock_code(lock_code), .lock_addr(lock_addr),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
        .op_done(op_done), .op_allow(op_allow), .op_reject(op_reject),
        .id_addr(id_addr), .id_hit(id_hit), .id_status(id_status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // size: 0 open, 1 16K, 2 64K
    function automatic int status_of(input int size);
        return (size == 0) ? 0 : (size == 1) ? 2 : 3;
    endfunction

    function automatic bit exp_reject(input int kind, input int unsigned a, input int t, input int b);
        int unsigned lo, hi;
        bit r = 0;
        case (kind)
            0: begin lo = a;               hi = a;              end
            1: begin lo = a & ~32'hFFF;    hi = a | 32'hFFF;    end
            2: begin lo = a & ~32'hFFFF;   hi = a | 32'hFFFF;   end
            default: begin lo = 0;         hi = 32'h7FFFF;      end
        endcase
        if (t != 0 && hi >= ((t == 1) ? 32'h7C000 : 32'h70000)) r = 1;
        if (b != 0 && lo <= ((b == 1) ? 32'h03FFF : 32'h0FFFF)) r = 1;
        return r;
    endfunction

    task automatic send_lock(input logic [7:0] code, input logic [18:0] a);
        @(negedge clk);
        lock_req = 1'b1; lock_code = code; lock_addr = a;
        @(negedge clk);
        lock_req = 1'b0;
    endtask

    task automatic factory_clear();
        @(negedge clk);
        factory_rst = 1'b1;
        @(negedge clk);
        factory_rst = 1'b0;
    endtask

    task automatic read_status(input logic [18:0] a, input int exp, input bit exp_hit, input string req);
        id_addr = a;
        #1;
        check(id_status == 8'(exp), req, id_status, exp);
        check(id_hit == exp_hit, req, id_hit, exp_hit);
    endtask

    task automatic run_op(input int kind, input int unsigned a, input bit exp_rej, input string req);
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'(kind); op_addr = 19'(a);
        @(negedge clk);
        op_valid = 1'b0;
        check(op_done && (op_reject == exp_rej) && (op_allow == !exp_rej), req,
              {op_done, op_allow, op_reject}, {1'b1, !exp_rej, exp_rej});
    endtask

    int unsigned addrs [11] = '{32'h00000, 32'h03FFF, 32'h04000, 32'h0FFFF, 32'h10000,
                                32'h40000, 32'h6FFFF, 32'h70000, 32'h7BFFF, 32'h7C000, 32'h7FFFF};

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0; factory_rst = 1'b0;
        // R1: reset state
        check(op_done == 1'b0, "R1 done after reset", op_done, 0);
        read_status(19'h00002, 0, 1, "R1 bottom status");
        read_status(19'h7FFF2, 0, 1, "R1 top status");
        run_op(3, 0, 0, "R1 chip erase allowed when open");
        // R10: no request, no verdict
        repeat (3) begin
            @(negedge clk);
            check(op_done == 1'b0, "R10 idle done", op_done, 0);
        end
        // R3: malformed requests ignored
        send_lock(8'h41, 19'h7FFFF);
        send_lock(8'h40, 19'h12345);
        send_lock(8'h70, 19'h00001);
        read_status(19'h7FFF2, 0, 1, "R3 top unchanged");
        read_status(19'h00002, 0, 1, "R3 bottom unchanged");
        run_op(0, 32'h7FFFF, 0, "R3 program top allowed");
        run_op(0, 32'h00000, 0, "R3 program bottom allowed");
        // R4: relock ignored
        send_lock(8'h40, 19'h7FFFF);
        send_lock(8'h70, 19'h7FFFF);
        read_status(19'h7FFF2, 2, 1, "R4 top stays 16K");
        run_op(0, 32'h70000, 0, "R4 64K area still open");
        run_op(0, 32'h7C000, 1, "R4 16K area locked");
        // R5: ordinary reset keeps lock, clears verdict
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'b00; op_addr = 19'h7C000;
        rst = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; rst = 1'b0;
        check(op_done == 1'b0 && op_reject == 1'b0, "R5 verdict cleared", {op_done, op_reject}, 0);
        read_status(19'h7FFF2, 2, 1, "R5 lock kept");
        run_op(0, 32'h7C000, 1, "R5 lock still enforced");
        // R11: non-status addresses
        read_status(19'h00003, 0, 0, "R11 other address");
        read_status(19'h7FFF3, 0, 0, "R11 other address high");

        // Sweep all nine lock combinations (R2, R6, R7, R8, R9, R11)
        for (int t = 0; t < 3; t++) begin
            for (int b = 0; b < 3; b++) begin
                factory_clear();
                read_status(19'h7FFF2, 0, 1, "R1 cleared top");
                if (t != 0) send_lock((t == 1) ? 8'h40 : 8'h70, 19'h7FFFF);
                if (b != 0) send_lock((b == 1) ? 8'h40 : 8'h70, 19'h00000);
                read_status(19'h7FFF2, status_of(t), 1, "R2 R11 top status");
                read_status(19'h00002, status_of(b), 1, "R2 R11 bottom status");
                for (int k = 0; k < 4; k++) begin
                    foreach (addrs[i]) begin
                        run_op(k, addrs[i], exp_reject(k, addrs[i], t, b),
                               (k == 0) ? "R7 R6 program" : (k == 3) ? "R9 chip erase" : "R8 R6 erase");
                    end
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule